// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit decides which interrupt source a 16550-style UART presents to software and drives the shared interrupt line. Every cycle it looks at the enable bits, the receive FIFO fill count, the overrun flag, the transmit-empty status and the modem-status change flags. From these it picks the most urgent pending source and registers an identification byte that a register read returns.

The transmit-empty source needs an acknowledge. When a read returns the transmit-empty code, an internal latch is set and the source stops being reported. A write to the transmit holding register or to the enable register clears the latch again. A one-cycle strobe marks each read that consumed the transmit-empty report. The receive-timeout code is reported at once whenever the received data is below the trigger level. There is no idle timer.

The FIFOs, the address decoding and the serial shifters sit outside the unit. The surrounding logic asserts `id_rd` in the cycle it samples `id_byte` for a read of the identification register.

Top module: `uart_irq_ident`

## Requirements
- R1: During and right after reset, `id_byte` is 0x01, `irq` is 0, `tx_ack_strobe` is 0, and the acknowledge latch is clear.
- R2: When several sources are pending, the reported source follows this priority: line status, then received data or timeout, then transmit-empty, then modem status.
- R3: Line status is pending when `irq_en[2]` is 1 and `rx_overrun` is 1. Its code is 0x06 in `id_byte[3:0]`.
- R4: When `irq_en[0]` is 1 and `rx_count` is nonzero, the unit reports code 0x04 if `rx_count` is at or above the trigger level, and 0x0C otherwise. With `fifo_on` set, `trig_sel` 0/1/2/3 selects a level of 1/4/8/14. With `fifo_on` clear, the level is 1.
- R5: Transmit-empty (code 0x02) is pending when `irq_en[1]` is 1, `tx_empty` is 1 and the acknowledge latch is clear.
- R6: A cycle with `id_rd` high, while `id_byte[3:0]` shows 0x02, sets the acknowledge latch and raises `tx_ack_strobe` for the following cycle. No other cycle raises the strobe.
- R7: `thr_wr` or `ier_wr` clears the acknowledge latch. A clear wins over a set in the same cycle.
- R8: Modem status (code 0x00) is pending when `irq_en[3]` is 1 and any of `d_cts`, `d_dsr`, `d_dcd` or `ri_trail` is 1.
- R9: `irq` is 1 exactly when, in the previous cycle, some source was pending and `out2` was 1.
- R10: `id_byte` reflects the inputs of the previous cycle. Bit 0 is 1 when nothing is pending, and the code bits [3:1] are then 0. Bits 5:4 are 0. Bits 7:6 are 11 when `fifo_on` is set and 00 when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 4 | Enables: [0] rx data, [1] tx empty, [2] line status, [3] modem |
| fifo_on | input | 1 | FIFO mode enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_overrun | input | 1 | Receive overrun flag |
| tx_empty | input | 1 | Transmit path empty |
| d_cts | input | 1 | CTS changed |
| d_dsr | input | 1 | DSR changed |
| d_dcd | input | 1 | DCD changed |
| ri_trail | input | 1 | Ring indicator trailing edge seen |
| out2 | input | 1 | Modem control OUT2 bit, gates the interrupt line |
| id_rd | input | 1 | Identification register read in this cycle |
| thr_wr | input | 1 | Transmit holding register write |
| ier_wr | input | 1 | Enable register write |
| id_byte | output | 8 | Registered identification byte |
| tx_ack_strobe | output | 1 | Pulse: a read consumed the transmit-empty report |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check the following on every cycle:
- the layout of the identification byte;
- that `irq` implies both `out2` and a pending code;
- that line status overrides everything else;
- that a strobe only follows a read of the transmit-empty code;
- that a write always leaves the latch clear.

The bench's scenarios cover the rest: the exact choice between received data and timeout at each trigger level, the full priority chain, and the acknowledge sequence of read, then silence, then re-arming by a write. These behaviours need a model of the acknowledge latch and of the count thresholds.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       irq_en,
  input  logic             fifo_on,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_overrun,
  input  logic             tx_empty,
  input  logic             d_cts,
  input  logic             d_dsr,
  input  logic             d_dcd,
  input  logic             ri_trail,
  input  logic             out2,
  input  logic             id_rd,
  input  logic             thr_wr,
  input  logic             ier_wr,
  output logic [7:0]       id_byte,
  output logic             tx_ack_strobe,
  output logic             irq
);
  localparam logic [3:0] C_LINE = 4'h6;
  localparam logic [3:0] C_RXD  = 4'h4;
  localparam logic [3:0] C_TMO  = 4'hC;
  localparam logic [3:0] C_THR  = 4'h2;
  localparam logic [3:0] C_MDM  = 4'h0;
  localparam logic [3:0] C_NONE = 4'h1;

  logic             ack_q;
  logic [7:0]       id_q;
  logic             strobe_q, irq_q;
  logic [CNT_W-1:0] trig;
  logic [3:0]       code;
  logic             line_p, rx_p, thr_p, mdm_p, any_p;
  logic             ack_set, ack_clr;

  always_comb begin
    if (!fifo_on) trig = CNT_W'(1);
    else begin
      case (trig_sel)
        2'd0:    trig = CNT_W'(LVL0);
        2'd1:    trig = CNT_W'(LVL1);
        2'd2:    trig = CNT_W'(LVL2);
        default: trig = CNT_W'(LVL3);
      endcase
    end
  end

  assign line_p = irq_en[2] & rx_overrun;
  assign rx_p   = irq_en[0] & (rx_count != '0);
  assign thr_p  = irq_en[1] & tx_empty & ~ack_q;
  assign mdm_p  = irq_en[3] & (d_cts | d_dsr | d_dcd | ri_trail);
  assign any_p  = line_p | rx_p | thr_p | mdm_p;

  always_comb begin
    if (line_p)     code = C_LINE;
    else if (rx_p)  code = (rx_count >= trig) ? C_RXD : C_TMO;
    else if (thr_p) code = C_THR;
    else if (mdm_p) code = C_MDM;
    else            code = C_NONE;
  end

  assign ack_set = id_rd & (id_q[3:0] == C_THR);
  assign ack_clr = thr_wr | ier_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      id_q     <= {4'h0, C_NONE};
      strobe_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ack_clr)      ack_q <= 1'b0;
      else if (ack_set) ack_q <= 1'b1;
      id_q     <= {{2{fifo_on}}, 2'b00, code};
      strobe_q <= ack_set;
      irq_q    <= any_p & out2;
    end
  end

  assign id_byte       = id_q;
  assign tx_ack_strobe = strobe_q;
  assign irq           = irq_q;
endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_en,
  input logic       rx_overrun,
  input logic       out2,
  input logic       id_rd,
  input logic       thr_wr,
  input logic       ier_wr,
  input logic [7:0] id_byte,
  input logic       tx_ack_strobe,
  input logic       irq,
  input logic       ack_q
);
  logic live;
  always_ff @(posedge clk)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  p_idle_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_byte[0] |-> (id_byte[3:1] == 3'b000));
  p_fifo_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_byte[5:4] == 2'b00) && (id_byte[7:6] != 2'b01) && (id_byte[7:6] != 2'b10));
  p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !id_byte[0]);
  p_irq_out2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && irq) |-> $past(out2));
  p_line_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(irq_en[2] && rx_overrun)) |-> (id_byte[3:0] == 4'h6));
  p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tx_ack_strobe) |-> ($past(id_rd) && $past(id_byte[3:0]) == 4'h2));
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(thr_wr || ier_wr)) |-> !ack_q);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rx_overrun(rx_overrun),
  .out2(out2), .id_rd(id_rd), .thr_wr(thr_wr), .ier_wr(ier_wr),
  .id_byte(id_byte), .tx_ack_strobe(tx_ack_strobe), .irq(irq), .ack_q(ack_q)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CNT_W = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] irq_en = '0;
  logic fifo_on = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic rx_overrun = 1'b0, tx_empty = 1'b0;
  logic d_cts = 1'b0, d_dsr = 1'b0, d_dcd = 1'b0, ri_trail = 1'b0;
  logic out2 = 1'b0, id_rd = 1'b0, thr_wr = 1'b0, ier_wr = 1'b0;
  logic [7:0] id_byte;
  logic tx_ack_strobe, irq;

  int checks = 0, fails = 0;
  bit m_ack = 1'b0;
  logic [7:0] prev_exp = 8'h01;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .fifo_on(fifo_on),
    .trig_sel(trig_sel), .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_empty(tx_empty), .d_cts(d_cts), .d_dsr(d_dsr), .d_dcd(d_dcd),
    .ri_trail(ri_trail), .out2(out2), .id_rd(id_rd), .thr_wr(thr_wr),
    .ier_wr(ier_wr), .id_byte(id_byte), .tx_ack_strobe(tx_ack_strobe), .irq(irq)
  );

  function automatic int level();
    if (!fifo_on) return 1;
    case (trig_sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] model_id(bit ack);
    logic [3:0] c;
    if (irq_en[2] && rx_overrun) c = 4'h6;
    else if (irq_en[0] && rx_count != 0) c = (int'(rx_count) >= level()) ? 4'h4 : 4'hC;
    else if (irq_en[1] && tx_empty && !ack) c = 4'h2;
    else if (irq_en[3] && (d_cts || d_dsr || d_dcd || ri_trail)) c = 4'h0;
    else c = 4'h1;
    return {{2{fifo_on}}, 2'b00, c};
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'h6: return "R3";
      4'h4, 4'hC: return "R4";
      4'h2: return "R5";
      4'h0: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(string req);
    logic [7:0] e_id;
    bit e_str, e_irq;
    e_id  = model_id(m_ack);
    e_str = id_rd && (prev_exp[3:0] == 4'h2);
    e_irq = !e_id[0] && out2;
    if (thr_wr || ier_wr) m_ack = 1'b0;
    else if (e_str) m_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(id_byte == e_id, (req != "") ? req : tag_of(e_id[3:0]), id_byte, e_id);
    check(tx_ack_strobe == e_str, "R6", {7'b0, tx_ack_strobe}, {7'b0, e_str});
    check(irq == e_irq, "R9", {7'b0, irq}, {7'b0, e_irq});
    prev_exp = e_id;
  endtask

  task automatic quiet();
    irq_en = '0; fifo_on = 0; trig_sel = 0; rx_count = 0; rx_overrun = 0;
    tx_empty = 0; d_cts = 0; d_dsr = 0; d_dcd = 0; ri_trail = 0;
    out2 = 0; id_rd = 0; thr_wr = 0; ier_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check(id_byte == 8'h01, "R1", id_byte, 8'h01);
    check(tx_ack_strobe == 1'b0 && irq == 1'b0, "R1", {6'b0, tx_ack_strobe, irq}, 8'h00);
    rst_n = 1'b1;

    // R2: every source active, line status wins; then peel off one by one
    irq_en = 4'hF; fifo_on = 1; rx_overrun = 1; rx_count = 5'd3; tx_empty = 1;
    d_cts = 1; out2 = 1;
    step("R2");
    rx_overrun = 0; step("R2");
    rx_count = 0; step("R2");
    tx_empty = 0; step("R2");
    d_cts = 0; ri_trail = 1; step("R8");
    ri_trail = 0; d_dsr = 1; out2 = 0; step("R9");
    d_dsr = 0; d_dcd = 1; irq_en = 4'h7; step("R8");
    d_dcd = 0; step("R10");

    // R4: trigger thresholds on both sides of each level
    irq_en = 4'h1; out2 = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int c = 1; c < 16; c++) begin
        rx_count = 5'(c);
        step("R4");
      end
    end
    fifo_on = 0; rx_count = 1; step("R4");

    // R5/R6/R7: acknowledge sequence
    quiet(); irq_en = 4'h2; tx_empty = 1; out2 = 1; fifo_on = 1;
    step("R5");
    id_rd = 1; step("R6");
    id_rd = 0; step("R6");
    step("R6");
    thr_wr = 1; step("R7");
    thr_wr = 0; step("R7");
    id_rd = 1; step("R6");
    id_rd = 0; step("R6");
    ier_wr = 1; step("R7");
    ier_wr = 0; step("R7");
    id_rd = 1; thr_wr = 1; step("R7");
    id_rd = 0; thr_wr = 0; step("R7");
    step("R7");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      irq_en     = 4'($urandom);
      fifo_on    = ($urandom % 4) != 0;
      trig_sel   = 2'($urandom);
      rx_count   = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom % 17);
      rx_overrun = ($urandom % 6) == 0;
      tx_empty   = ($urandom % 4) != 0;
      d_cts      = ($urandom % 8) == 0;
      d_dsr      = ($urandom % 8) == 0;
      d_dcd      = ($urandom % 8) == 0;
      ri_trail   = ($urandom % 8) == 0;
      out2       = ($urandom % 4) != 0;
      id_rd      = ($urandom % 2) == 0;
      thr_wr     = ($urandom % 10) == 0;
      ier_wr     = ($urandom % 12) == 0;
      step("");
    end
    finish_run();
  end
endmodule